// File: doc/BRIEF.md
# Active Priority Tracking Unit

This block holds the interrupt nesting state of each processor in an interrupt controller. It keeps no list of active interrupt identifiers. Each processor has two bitmaps, one bit per preemption level: one for secure (group 0) interrupts and one for non-secure (group 1) interrupts. When an interrupt is granted, the bit for its preemption level is set. When an interrupt is completed, the lowest set bit of the bitmap for its group is cleared. The running priority of each processor is the priority of the lowest level set in either bitmap, or an idle value when both bitmaps are empty.

The pending-selection logic drives the acknowledge strobe with the granted interrupt's identifier, group priority and group. The completion path drives the end-of-interrupt strobe with the identifier, the group and the security of the access. Priority comparison elsewhere reads the registered running priority of each processor. The completion order must nest with the acknowledge order, because a completion always retires the most urgent active level of its group.

Top module: `apt_unit`

## Requirements
- R1: After reset, the running priority of every CPU is the idle value 0x100 and both of its bitmaps are empty.
- R2: An acknowledge with an identifier below NUM_IRQ sets bit `gprio >> (MIN_BPR+1)`. The bit goes into the non-secure bitmap when groups are supported and `ack_group1` is 1. Otherwise it goes into the secure bitmap.
- R3: After such an acknowledge, the running priority of that CPU equals the acknowledged group priority with its low MIN_BPR+1 bits cleared. A lower-urgency acknowledge still overwrites it.
- R4: An accepted end-of-interrupt clears only the lowest set bit of the bitmap for its group. Group 1 is chosen when groups are supported and `eoi_group1` is 1. The other bitmap is untouched, even when it holds the same level.
- R5: After an accepted end-of-interrupt, the running priority is (lowest level set in either bitmap) << (MIN_BPR+1). It is 0x100 when both bitmaps are empty.
- R6: An end-of-interrupt whose identifier is NUM_IRQ or more has no effect.
- R7: An end-of-interrupt that arrives while the CPU's running priority is 0x100 has no effect.
- R8: When the security extension is present, a non-secure end-of-interrupt (`eoi_nonsecure`=1) for a group 0 interrupt has no effect.
- R9: An acknowledge whose identifier is NUM_IRQ or more (for example the spurious value 1023) has no effect.
- R10: If an acknowledge and an end-of-interrupt name the same CPU in the same cycle, the acknowledge is applied and the end-of-interrupt is discarded.
- R11: Each CPU's state changes only for events that name that CPU. CPU c's running priority is bits [c*9 +: 9] of `rpr_o`.
- R12: The running priority is registered. It changes on the first clock edge at which the strobe is sampled and holds until then.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ack_valid | input | 1 | Acknowledge strobe, one cycle |
| ack_cpu | input | CPU_W | CPU taking the interrupt |
| ack_id | input | ID_W | Granted interrupt identifier |
| ack_gprio | input | PRIO_W | Group priority of the granted interrupt |
| ack_group1 | input | 1 | Granted interrupt belongs to group 1 |
| eoi_valid | input | 1 | End-of-interrupt strobe, one cycle |
| eoi_cpu | input | CPU_W | CPU completing the interrupt |
| eoi_id | input | ID_W | Completed interrupt identifier |
| eoi_group1 | input | 1 | Completed interrupt belongs to group 1 |
| eoi_nonsecure | input | 1 | Completion arrived as a non-secure access |
| rpr_o | output | NUM_CPU*(PRIO_W+1) | Running priority of every CPU, packed |

## Verification
The hardest case to reach is a single preemption level that is active in both groups at once, followed by completions that retire it group by group. It is also hard to reach a completion aimed at an empty group while the other group still holds active levels. In both cases the running priority must stay put where a naive design would drop it. The random stimulus draws group priorities from only eight values and mixes the two groups, so level collisions between the groups are common. A directed sequence builds the shared-level case on purpose and drains it one group at a time.

// File: rtl/apt_pkg.sv
package apt_pkg;
   typedef enum logic {
      GRP_SECURE = 1'b0,
      GRP_NONSEC = 1'b1
   } apt_grp_e;

   function automatic int unsigned apt_width(input int unsigned n);
      return (n <= 1) ? 1 : $clog2(n);
   endfunction
endpackage

// File: rtl/apt_lsb_enc.sv
module apt_lsb_enc #(
   parameter int W     = 128,
   parameter int IDX_W = (W <= 1) ? 1 : $clog2(W)
) (
   input  logic [W-1:0]     vec,
   output logic             found,
   output logic [IDX_W-1:0] idx
);
   if (W < 2) begin : g_bad_w
      $error("apt_lsb_enc: W must be at least 2");
   end

   always_comb begin
      found = |vec;
      idx   = '0;
      for (int i = W - 1; i >= 0; i--) begin
         if (vec[i]) idx = i[IDX_W-1:0];
      end
   end
endmodule

// File: rtl/apt_cpu_slice.sv
module apt_cpu_slice
   import apt_pkg::*;
#(
   parameter int PRIO_W = 8,
   parameter int SH     = 1,
   localparam int LVL_W  = PRIO_W - SH,
   localparam int NLEVEL = 1 << LVL_W
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             ack_stb,
   input  logic [LVL_W-1:0] ack_lvl,
   input  apt_grp_e         ack_grp,
   input  logic             eoi_stb,
   input  apt_grp_e         eoi_grp,
   output logic [PRIO_W:0]  rpr_o
);
   localparam logic [PRIO_W:0] IDLE = {1'b1, {PRIO_W{1'b0}}};

   logic [NLEVEL-1:0] act_s, act_ns, s_clr, ns_clr, s_nx, ns_nx, set_vec;
   logic [PRIO_W:0]   rpr_q, rpr_nx;
   logic              eoi_take, low_found;
   logic [LVL_W-1:0]  low_idx;

   assign eoi_take = eoi_stb && (rpr_q != IDLE);
   assign set_vec  = NLEVEL'(1) << ack_lvl;
   assign s_clr    = (eoi_take && eoi_grp == GRP_SECURE) ? (act_s & (act_s - NLEVEL'(1))) : act_s;
   assign ns_clr   = (eoi_take && eoi_grp == GRP_NONSEC) ? (act_ns & (act_ns - NLEVEL'(1))) : act_ns;

   apt_lsb_enc #(.W(NLEVEL), .IDX_W(LVL_W)) u_enc (
      .vec   (s_clr | ns_clr),
      .found (low_found),
      .idx   (low_idx)
   );

   always_comb begin
      s_nx   = act_s;
      ns_nx  = act_ns;
      rpr_nx = rpr_q;
      if (ack_stb) begin
         if (ack_grp == GRP_NONSEC) ns_nx = act_ns | set_vec;
         else                       s_nx  = act_s | set_vec;
         rpr_nx = {1'b0, ack_lvl, {SH{1'b0}}};
      end else if (eoi_take) begin
         s_nx   = s_clr;
         ns_nx  = ns_clr;
         rpr_nx = low_found ? {1'b0, low_idx, {SH{1'b0}}} : IDLE;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         act_s  <= '0;
         act_ns <= '0;
         rpr_q  <= IDLE;
      end else begin
         act_s  <= s_nx;
         act_ns <= ns_nx;
         rpr_q  <= rpr_nx;
      end
   end

   assign rpr_o = rpr_q;

   // R1
   idle_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ((act_s | act_ns) == '0) == (rpr_q == IDLE));

   // R2
   ack_sets_bit_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ack_stb |=> ($past(ack_grp) == GRP_NONSEC ? act_ns[$past(ack_lvl)] : act_s[$past(ack_lvl)]));

   // R7
   idle_eoi_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (eoi_stb && !ack_stb && rpr_q == IDLE) |=> (rpr_q == IDLE && $stable(act_s) && $stable(act_ns)));

   // R4
   one_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (eoi_stb && !ack_stb && rpr_q != IDLE &&
       ((eoi_grp == GRP_NONSEC) ? (act_ns != '0) : (act_s != '0)))
      |=> (($countones(act_s) + $countones(act_ns)) ==
           $past($countones(act_s) + $countones(act_ns)) - 1));
endmodule

// File: rtl/apt_unit.sv
module apt_unit
   import apt_pkg::*;
#(
   parameter int NUM_CPU      = 2,
   parameter int PRIO_W       = 8,
   parameter int MIN_BPR      = 0,
   parameter int NUM_IRQ      = 96,
   parameter int ID_W         = 10,
   parameter bit HAS_GROUPS   = 1'b1,
   parameter bit HAS_SECURITY = 1'b1,
   localparam int CPU_W = apt_width(NUM_CPU),
   localparam int SH    = MIN_BPR + 1,
   localparam int LVL_W = PRIO_W - SH,
   localparam int RPR_W = PRIO_W + 1
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     ack_valid,
   input  logic [CPU_W-1:0]         ack_cpu,
   input  logic [ID_W-1:0]          ack_id,
   input  logic [PRIO_W-1:0]        ack_gprio,
   input  logic                     ack_group1,
   input  logic                     eoi_valid,
   input  logic [CPU_W-1:0]         eoi_cpu,
   input  logic [ID_W-1:0]          eoi_id,
   input  logic                     eoi_group1,
   input  logic                     eoi_nonsecure,
   output logic [NUM_CPU*RPR_W-1:0] rpr_o
);
   localparam logic [ID_W-1:0] IRQ_LIM = ID_W'(NUM_IRQ);

   if (NUM_CPU < 1) begin : g_bad_cpu
      $error("apt_unit: NUM_CPU must be at least 1");
   end
   if (MIN_BPR < 0 || MIN_BPR > PRIO_W - 2) begin : g_bad_bpr
      $error("apt_unit: MIN_BPR out of range");
   end
   if (NUM_IRQ < 1 || NUM_IRQ >= (1 << ID_W)) begin : g_bad_irq
      $error("apt_unit: NUM_IRQ must fit below 2**ID_W");
   end

   apt_grp_e ack_grp, eoi_grp;
   logic     eoi_ok, ack_ok;

   if (HAS_GROUPS) begin : g_grp
      assign ack_grp = ack_group1 ? GRP_NONSEC : GRP_SECURE;
      assign eoi_grp = eoi_group1 ? GRP_NONSEC : GRP_SECURE;
   end else begin : g_nogrp
      assign ack_grp = GRP_SECURE;
      assign eoi_grp = GRP_SECURE;
   end

   if (HAS_SECURITY) begin : g_sec
      assign eoi_ok = (eoi_id < IRQ_LIM) && !(eoi_nonsecure && eoi_grp == GRP_SECURE);
   end else begin : g_nosec
      assign eoi_ok = (eoi_id < IRQ_LIM);
   end

   assign ack_ok = ack_valid && (ack_id < IRQ_LIM);

   for (genvar c = 0; c < NUM_CPU; c++) begin : g_cpu
      logic ack_here, eoi_here;
      assign ack_here = ack_ok && (ack_cpu == CPU_W'(c));
      assign eoi_here = eoi_valid && eoi_ok && (eoi_cpu == CPU_W'(c)) &&
                        !(ack_valid && ack_cpu == CPU_W'(c));

      apt_cpu_slice #(.PRIO_W(PRIO_W), .SH(SH)) u_slice (
         .clk     (clk),
         .rst_n   (rst_n),
         .ack_stb (ack_here),
         .ack_lvl (ack_gprio[PRIO_W-1:SH]),
         .ack_grp (ack_grp),
         .eoi_stb (eoi_here),
         .eoi_grp (eoi_grp),
         .rpr_o   (rpr_o[c*RPR_W +: RPR_W])
      );

      // R3
      low_bits_chk: assert property (@(posedge clk) disable iff (!rst_n)
         rpr_o[c*RPR_W +: SH] == '0);

      // R6
      eoi_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
         (eoi_valid && eoi_cpu == CPU_W'(c) && eoi_id >= IRQ_LIM &&
          !(ack_valid && ack_cpu == CPU_W'(c))) |=> $stable(rpr_o[c*RPR_W +: RPR_W]));

      // R9
      ack_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
         (ack_valid && ack_cpu == CPU_W'(c) && ack_id >= IRQ_LIM)
         |=> $stable(rpr_o[c*RPR_W +: RPR_W]));

      // R11
      other_cpu_chk: assert property (@(posedge clk) disable iff (!rst_n)
         (!(ack_valid && ack_cpu == CPU_W'(c)) && !(eoi_valid && eoi_cpu == CPU_W'(c)))
         |=> $stable(rpr_o[c*RPR_W +: RPR_W]));
   end
endmodule

// File: tb/tb_apt_unit.sv
module tb_apt_unit;
   localparam int NCPU = 2;
   localparam int NIRQ = 96;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        ack_valid = 0, ack_group1 = 0, eoi_valid = 0, eoi_group1 = 0, eoi_nonsecure = 0;
   logic [0:0]  ack_cpu = 0, eoi_cpu = 0;
   logic [9:0]  ack_id = 0, eoi_id = 0;
   logic [7:0]  ack_gprio = 0;
   logic [17:0] rpr_o;

   int tests = 0, fails = 0;
   bit done = 0;

   logic [127:0] ms [NCPU];
   logic [127:0] mns[NCPU];
   logic [8:0]   mr [NCPU];

   always #4 clk = ~clk;

   apt_unit dut (
      .clk(clk), .rst_n(rst_n),
      .ack_valid(ack_valid), .ack_cpu(ack_cpu), .ack_id(ack_id),
      .ack_gprio(ack_gprio), .ack_group1(ack_group1),
      .eoi_valid(eoi_valid), .eoi_cpu(eoi_cpu), .eoi_id(eoi_id),
      .eoi_group1(eoi_group1), .eoi_nonsecure(eoi_nonsecure),
      .rpr_o(rpr_o)
   );

   function automatic int lowest(input logic [127:0] v);
      for (int i = 0; i < 128; i++) if (v[i]) return i;
      return -1;
   endfunction

   task automatic check_all(input string req);
      for (int c = 0; c < NCPU; c++) begin
         tests++;
         if (rpr_o[c*9 +: 9] !== mr[c]) begin
            fails++;
            $display("FAIL %s cpu%0d rpr actual=%h expected=%h", req, c, rpr_o[c*9 +: 9], mr[c]);
         end
      end
   endtask

   task automatic model_ack(input int c, input logic [9:0] id, input logic [7:0] p, input logic g1);
      int lvl;
      if (id >= NIRQ) return;
      lvl = int'(p) / 2;
      if (g1) mns[c][lvl] = 1'b1;
      else    ms[c][lvl]  = 1'b1;
      mr[c] = 9'(lvl * 2);
   endtask

   task automatic model_eoi(input int c, input logic [9:0] id, input logic g1, input logic ns);
      int k;
      if (id >= NIRQ) return;
      if (mr[c] == 9'h100) return;
      if (ns && !g1) return;
      if (g1) begin
         k = lowest(mns[c]);
         if (k >= 0) mns[c][k] = 1'b0;
      end else begin
         k = lowest(ms[c]);
         if (k >= 0) ms[c][k] = 1'b0;
      end
      k = lowest(ms[c] | mns[c]);
      mr[c] = (k < 0) ? 9'h100 : 9'(k * 2);
   endtask

   // Called 2 ns after a rising edge; drives, checks hold (R12), clocks, checks result.
   task automatic step(input logic av, input int ac, input logic [9:0] aid, input logic [7:0] ap,
                       input logic ag, input logic ev, input int ec, input logic [9:0] eid,
                       input logic eg, input logic ens, input string req);
      ack_valid = av; ack_cpu = 1'(ac); ack_id = aid; ack_gprio = ap; ack_group1 = ag;
      eoi_valid = ev; eoi_cpu = 1'(ec); eoi_id = eid; eoi_group1 = eg; eoi_nonsecure = ens;
      #1;
      check_all("R12");
      if (av) model_ack(ac, aid, ap, ag);
      if (ev && !(av && ac == ec)) model_eoi(ec, eid, eg, ens);
      @(posedge clk); #2;
      ack_valid = 0; eoi_valid = 0;
      check_all(req);
   endtask

   task automatic ack(input int c, input logic [7:0] p, input logic g1, input string req);
      step(1, c, 10'd7, p, g1, 0, 0, 0, 0, 0, req);
   endtask

   task automatic eoi(input int c, input logic [9:0] id, input logic g1, input logic ns, input string req);
      step(0, 0, 0, 0, 0, 1, c, id, g1, ns, req);
   endtask

   initial begin
      #(200000 * 8);
      if (!done) begin
         fails++;
         tests++;
         $display("FAIL watchdog expired");
         $display("  [TB] %0d tests run, %0d failed", tests, fails);
         $finish;
      end
   end

   initial begin
      for (int c = 0; c < NCPU; c++) begin ms[c] = '0; mns[c] = '0; mr[c] = 9'h100; end
      repeat (3) @(posedge clk);
      #2 rst_n = 1'b1;
      @(posedge clk); #2;
      check_all("R1");

      eoi(0, 10'd5, 0, 0, "R7");              // nothing active
      ack(0, 8'h40, 0, "R3");
      ack(1, 8'h41, 0, "R3");                  // odd bit dropped
      ack(0, 8'h10, 1, "R2");
      eoi(0, 10'd100, 1, 0, "R6");             // id out of range
      eoi(0, 10'd3, 0, 1, "R8");               // non-secure on group 0
      eoi(0, 10'd3, 1, 1, "R4");               // back to 0x40
      check_all("R11");
      ack(0, 8'h20, 0, "R2");
      ack(0, 8'h20, 1, "R2");                  // same level both groups
      eoi(0, 10'd4, 0, 0, "R4");               // ns bit still holds 0x20
      eoi(0, 10'd4, 1, 0, "R5");               // 0x40
      eoi(0, 10'd4, 1, 0, "R5");               // empty group 1: stays 0x40
      step(1, 0, 10'd9, 8'h08, 0, 1, 0, 10'd9, 0, 0, "R10");
      eoi(0, 10'd9, 0, 0, "R5");               // 0x40
      step(1, 0, 10'd1023, 8'h02, 0, 0, 0, 0, 0, 0, "R9");
      ack(0, 8'h90, 0, "R3");                  // lower urgency overwrites
      eoi(0, 10'd2, 0, 0, "R5");
      eoi(0, 10'd2, 0, 0, "R5");               // drained to idle
      eoi(1, 10'd2, 0, 0, "R5");

      for (int n = 0; n < 3000; n++) begin
         int sel = int'($urandom_range(0, 9));
         logic [7:0] p = 8'(($urandom_range(0, 7)) * 16 + $urandom_range(0, 1));
         if (sel < 4)
            ack(int'($urandom_range(0, 1)), p, 1'($urandom_range(0, 1)), "R2");
         else if (sel < 9)
            eoi(int'($urandom_range(0, 1)), (sel == 8) ? 10'd500 : 10'd11,
                1'($urandom_range(0, 1)), 1'($urandom_range(0, 3) == 0), "R5");
         else
            step(1, int'($urandom_range(0, 1)), 10'd12, p, 1'($urandom_range(0, 1)),
                 1, int'($urandom_range(0, 1)), 10'd12, 1'($urandom_range(0, 1)), 0, "R10");
      end

      done = 1;
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end

   initial void'($urandom(32'd1234));
endmodule